// File: doc/BRIEF.md
# Embedded Controller Host Handshake Port

This block is the controller side of a byte-wide host mailbox for an embedded controller. The host sees two ports selected by one address bit: a data port and a control port. Reading the control port returns a status byte. Writing it issues a command. The host moves a command through the block as a short run of bytes: an opcode, then an address, then an optional data byte. Two flags pace the exchange. The input-full flag tells the host that its last byte has not yet been taken. The output-full flag tells the host that a reply byte is waiting in the data port.

Behind the mailbox is a register space of up to 256 bytes, reached through a plain internal port. That port has an address, a write enable, write data and combinational read data. A read command copies one addressed byte out to the host. A write command stores one host byte at an address. Two further commands switch a burst flag on and off. A query command returns a fixed byte.

The block is built around four sequence states. ST_IDLE waits for an opcode. ST_RD_ADDR waits for the address of a read. ST_WR_ADDR waits for the address of a write. ST_WR_DATA waits for the byte to store.

The transitions are as follows:
- An opcode 0x80 taken in any state leads to ST_RD_ADDR.
- An opcode 0x81 taken in any state leads to ST_WR_ADDR.
- Any other opcode leads to ST_IDLE.
- A data byte taken in ST_RD_ADDR or ST_WR_DATA returns to ST_IDLE.
- A data byte taken in ST_WR_ADDR moves on to ST_WR_DATA.
- A data byte taken in ST_IDLE leaves the state unchanged.

Top module: `ec_host_port`

## Requirements
- R1: After reset the status byte reads 0x00, the data port reads 0x00, and the sequence is idle.
- R2: A host write to either port sets status bit 1 (input-full) at the next clock edge. The same edge sets status bit 3 to 1 when the byte went to the control port (host_sel=1) and to 0 when it went to the data port (host_sel=0).
- R3: A pending host byte is taken one clock edge after it was latched. Status bit 1 then clears unless another host write arrives on that same edge.
- R4: Opcode 0x80 followed by an address byte loads the addressed register into the data port and sets status bit 0 (output-full). Both happen on the edge that takes the address byte.
- R5: A host read of the data port (host_rd with host_sel=0) clears status bit 0. A new reply being loaded on the same edge takes priority, and the bit stays set.
- R6: Opcode 0x81, then an address byte, then a data byte produces exactly one single-cycle reg_we pulse. During that pulse, reg_addr is the address and reg_wdata is the data byte.
- R7: Opcode 0x82 sets status bit 4 (burst enabled), places BURST_ACK (default 0x90) in the data port and sets status bit 0.
- R8: Opcode 0x83 clears status bit 4 and leaves status bit 0 and the data port unchanged.
- R9: Opcode 0x84 places QUERY_VALUE in the data port and sets status bit 0.
- R10: Any opcode abandons a sequence in progress. An opcode outside 0x80–0x84 changes no register, leaves status bit 4, status bit 0 and the data port unchanged, and returns to idle. A data byte taken while idle is likewise ignored.
- R11: Status bits 2, 5, 6 and 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe; clears output-full when it reads the data port |
| host_sel | input | 1 | Port select: 0 data port, 1 control/status port |
| host_wdata | input | 8 | Byte written by the host |
| host_rdata | output | 8 | Status byte when host_sel=1, reply byte when host_sel=0 |
| reg_addr | output | ADDR_W | Register space address |
| reg_we | output | 1 | Register space write enable |
| reg_wdata | output | 8 | Register space write data |
| reg_rdata | input | 8 | Register space read data, combinational from reg_addr |

## Verification
The bench builds the block with ADDR_W=8, so the full 256-byte register space is reachable. It keeps BURST_ACK at 0x90. It sets QUERY_VALUE to 0xC3, so a query reply can be told apart from the reset value of the data port. A behavioural model runs alongside the block on every clock and predicts both port views and each register write pulse. Directed sequences then cover several cases:
- an opcode arriving in the middle of a write sequence;
- unknown opcodes;
- stray data bytes;
- a burst toggle with and without a pending reply.

// File: rtl/ec_host_pkg.sv
package ec_host_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_ADDR = 2'd1,
        ST_WR_ADDR = 2'd2,
        ST_WR_DATA = 2'd3
    } ec_state_t;

    localparam logic [7:0] OP_READ      = 8'h80;
    localparam logic [7:0] OP_WRITE     = 8'h81;
    localparam logic [7:0] OP_BURST_ON  = 8'h82;
    localparam logic [7:0] OP_BURST_OFF = 8'h83;
    localparam logic [7:0] OP_QUERY     = 8'h84;

    localparam int SB_OBF   = 0;
    localparam int SB_IBF   = 1;
    localparam int SB_CMD   = 3;
    localparam int SB_BURST = 4;

endpackage

// File: rtl/ec_inbuf.sv
module ec_inbuf #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_sel,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              consume,
    output logic              ibf,
    output logic              in_is_cmd,
    output logic [BYTE_W-1:0] in_byte
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibf       <= 1'b0;
            in_is_cmd <= 1'b0;
            in_byte   <= '0;
        end else if (host_wr) begin
            ibf       <= 1'b1;
            in_is_cmd <= host_sel;
            in_byte   <= host_wdata;
        end else if (consume) begin
            ibf       <= 1'b0;
        end
    end

endmodule

// File: rtl/ec_outbuf.sv
module ec_outbuf #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              host_rd,
    input  logic              host_sel,
    output logic              obf,
    output logic [BYTE_W-1:0] out_byte
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            obf      <= 1'b0;
            out_byte <= '0;
        end else if (load) begin
            obf      <= 1'b1;
            out_byte <= load_byte;
        end else if (host_rd && !host_sel) begin
            obf      <= 1'b0;
        end
    end

endmodule

// File: rtl/ec_seq_fsm.sv
module ec_seq_fsm
    import ec_host_pkg::*;
#(
    parameter int          BYTE_W      = 8,
    parameter int          ADDR_W      = 8,
    parameter logic [7:0]  QUERY_VALUE = 8'h00,
    parameter logic [7:0]  BURST_ACK   = 8'h90
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ibf,
    input  logic              in_is_cmd,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              consume,
    output logic              load,
    output logic [BYTE_W-1:0] load_byte,
    output logic              burst,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_we,
    output logic [BYTE_W-1:0] reg_wdata
);

    ec_state_t         state, nxt;
    logic [ADDR_W-1:0] addr_q;
    logic              burst_on, burst_off;
    logic              take_cmd, take_data;

    assign take_cmd  = ibf && in_is_cmd;
    assign take_data = ibf && !in_is_cmd;

    // next-state selection
    always_comb begin
        nxt = state;
        if (take_cmd) begin
            case (in_byte)
                OP_READ:  nxt = ST_RD_ADDR;
                OP_WRITE: nxt = ST_WR_ADDR;
                default:  nxt = ST_IDLE;
            endcase
        end else if (take_data) begin
            unique case (state)
                ST_IDLE:    nxt = ST_IDLE;
                ST_RD_ADDR: nxt = ST_IDLE;
                ST_WR_ADDR: nxt = ST_WR_DATA;
                ST_WR_DATA: nxt = ST_IDLE;
            endcase
        end
    end

    // state register and captured address / burst flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            burst  <= 1'b0;
        end else begin
            state <= nxt;
            if (take_data && state == ST_WR_ADDR)
                addr_q <= in_byte[ADDR_W-1:0];
            if (burst_on)
                burst <= 1'b1;
            else if (burst_off)
                burst <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        consume   = ibf;
        load      = 1'b0;
        load_byte = reg_rdata;
        burst_on  = 1'b0;
        burst_off = 1'b0;
        reg_addr  = addr_q;
        reg_we    = 1'b0;
        reg_wdata = in_byte;
        if (take_cmd) begin
            case (in_byte)
                OP_BURST_ON: begin
                    burst_on  = 1'b1;
                    load      = 1'b1;
                    load_byte = BURST_ACK;
                end
                OP_BURST_OFF: burst_off = 1'b1;
                OP_QUERY: begin
                    load      = 1'b1;
                    load_byte = QUERY_VALUE;
                end
                default: ;
            endcase
        end else if (take_data) begin
            unique case (state)
                ST_RD_ADDR: begin
                    reg_addr  = in_byte[ADDR_W-1:0];
                    load      = 1'b1;
                    load_byte = reg_rdata;
                end
                ST_WR_DATA: reg_we = 1'b1;
                ST_IDLE, ST_WR_ADDR: ;
            endcase
        end
    end

endmodule

// File: rtl/ec_host_port.sv
module ec_host_port
    import ec_host_pkg::*;
#(
    parameter int         ADDR_W      = 8,
    parameter logic [7:0] QUERY_VALUE = 8'h00,
    parameter logic [7:0] BURST_ACK   = 8'h90
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic              host_sel,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_we,
    output logic [7:0]        reg_wdata,
    input  logic [7:0]        reg_rdata
);

    localparam int BYTE_W = 8;

    logic              ibf_w, cmd_w, consume_w, load_w, obf_w, burst_w;
    logic [BYTE_W-1:0] in_byte_w, load_byte_w, out_byte_w, status_w;

    ec_inbuf #(.BYTE_W(BYTE_W)) u_inbuf (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .consume(consume_w),
        .ibf(ibf_w), .in_is_cmd(cmd_w), .in_byte(in_byte_w)
    );

    ec_seq_fsm #(
        .BYTE_W(BYTE_W), .ADDR_W(ADDR_W),
        .QUERY_VALUE(QUERY_VALUE), .BURST_ACK(BURST_ACK)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .ibf(ibf_w), .in_is_cmd(cmd_w),
        .in_byte(in_byte_w), .reg_rdata(reg_rdata), .consume(consume_w),
        .load(load_w), .load_byte(load_byte_w), .burst(burst_w),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata)
    );

    ec_outbuf #(.BYTE_W(BYTE_W)) u_outbuf (
        .clk(clk), .rst_n(rst_n), .load(load_w), .load_byte(load_byte_w),
        .host_rd(host_rd), .host_sel(host_sel),
        .obf(obf_w), .out_byte(out_byte_w)
    );

    always_comb begin
        status_w           = '0;
        status_w[SB_OBF]   = obf_w;
        status_w[SB_IBF]   = ibf_w;
        status_w[SB_CMD]   = cmd_w;
        status_w[SB_BURST] = burst_w;
    end

    assign host_rdata = host_sel ? status_w : out_byte_w;

endmodule

// File: rtl/ec_host_port_chk.sv
module ec_host_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr,
    input logic       host_rd,
    input logic       host_sel,
    input logic [7:0] host_wdata,
    input logic [7:0] status,
    input logic       load,
    input logic       reg_we
);

    // R2
    ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> status[1]);

    // R2
    cmd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel) |=> status[3]);

    // R2
    data_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_sel) |=> !status[3]);

    // R3
    ibf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && !host_wr) |=> !status[1]);

    // R4
    obf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> status[0]);

    // R5
    obf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_sel && !load) |=> !status[0]);

    // R6
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R7
    burst_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel && host_wdata == 8'h82) |=> ##1 (status[4] && status[0]));

    // R8
    burst_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel && host_wdata == 8'h83) |=> ##1 !status[4]);

    // R11
    zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7:5] == 3'b000) && !status[2]);

endmodule

bind ec_host_port ec_host_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .status(status_w),
    .load(load_w), .reg_we(reg_we)
);

// File: tb/ec_host_port_bench.sv
module ec_host_port_bench;

    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] QV  = 8'hC3;
    localparam logic [7:0] ACK = 8'h90;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0, host_sel = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [7:0] reg_addr;
    logic       reg_we;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;

    logic [7:0] mem [0:255];

    int total = 0;
    int fails = 0;
    bit model_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ec_host_port #(.ADDR_W(8), .QUERY_VALUE(QV), .BURST_ACK(ACK)) u_ec_host_port (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    assign reg_rdata = mem[reg_addr];
    always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

    // behavioural reference model
    logic [7:0] exp_mem [0:255];
    bit         m_ibf, m_cmd, m_obf, m_burst;
    logic [7:0] m_byte, m_out, m_addr;
    int         m_phase; // 0 idle, 1 read addr, 2 write addr, 3 write data

    always @(posedge clk) begin
        bit ld;
        if (!rst_n) begin
            m_ibf = 0; m_cmd = 0; m_obf = 0; m_burst = 0;
            m_byte = 0; m_out = 0; m_addr = 0; m_phase = 0;
        end else begin
            ld = 0;
            if (m_ibf) begin
                if (m_cmd) begin
                    m_phase = 0;
                    if (m_byte == 8'h80) m_phase = 1;
                    else if (m_byte == 8'h81) m_phase = 2;
                    else if (m_byte == 8'h82) begin m_burst = 1; m_out = ACK; ld = 1; end
                    else if (m_byte == 8'h83) m_burst = 0;
                    else if (m_byte == 8'h84) begin m_out = QV; ld = 1; end
                end else if (m_phase == 1) begin
                    m_out = exp_mem[m_byte]; ld = 1; m_phase = 0;
                end else if (m_phase == 2) begin
                    m_addr = m_byte; m_phase = 3;
                end else if (m_phase == 3) begin
                    exp_mem[m_addr] = m_byte; m_phase = 0;
                end
                m_ibf = 0;
            end
            if (ld) m_obf = 1;
            else if (host_rd && !host_sel) m_obf = 0;
            if (host_wr) begin m_ibf = 1; m_cmd = host_sel; m_byte = host_wdata; end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic peek(input bit sel, output logic [7:0] v);
        bit keep;
        keep = host_sel;
        host_sel = sel;
        #1 v = host_rdata;
        host_sel = keep;
    endtask

    // advance one clock, then compare against the model in the low phase
    task automatic tick();
        logic [7:0] s, d;
        bit exp_we;
        @(negedge clk);
        if (model_on) begin
            peek(1'b1, s);
            check(s == {3'b000, m_burst, m_cmd, 1'b0, m_ibf, m_obf},
                  "R2/R3/R5/R7 status vs model", s, {3'b000, m_burst, m_cmd, 1'b0, m_ibf, m_obf});
            peek(1'b0, d);
            check(d == m_out, "R4/R9 data port vs model", d, m_out);
            exp_we = m_ibf && !m_cmd && m_phase == 3;
            check(reg_we == exp_we, "R6 write pulse vs model", {7'd0, reg_we}, {7'd0, exp_we});
            if (exp_we) begin
                check(reg_addr == m_addr, "R6 write address", reg_addr, m_addr);
                check(reg_wdata == m_byte, "R6 write data", reg_wdata, m_byte);
            end
        end
    endtask

    task automatic wait_ibf_clear();
        logic [7:0] s;
        for (int i = 0; i < 500; i++) begin
            peek(1'b1, s);
            if (!s[1]) return;
            tick();
        end
        check(0, "R3 input-full never cleared", s, 8'h00);
    endtask

    task automatic host_write(input bit sel, input logic [7:0] b);
        wait_ibf_clear();
        host_sel = sel; host_wdata = b; host_wr = 1'b1;
        tick();
        host_wr = 1'b0;
        tick();
    endtask

    task automatic wait_obf(input string tag);
        logic [7:0] s;
        for (int i = 0; i < 500; i++) begin
            peek(1'b1, s);
            if (s[0]) return;
            tick();
        end
        check(0, tag, s, 8'h01);
    endtask

    task automatic host_read(output logic [7:0] b);
        host_sel = 1'b0;
        #1 b = host_rdata;
        host_rd = 1'b1;
        tick();
        host_rd = 1'b0;
        tick();
    endtask

    task automatic ec_rd(input logic [7:0] a, output logic [7:0] b);
        host_write(1'b1, 8'h80);
        host_write(1'b0, a);
        wait_obf("R4 reply never arrived");
        host_read(b);
    endtask

    task automatic ec_wr(input logic [7:0] a, input logic [7:0] b);
        host_write(1'b1, 8'h81);
        host_write(1'b0, a);
        host_write(1'b0, b);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual 0x00 expected 0x01");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] s, d;
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i) ^ 8'h5A;
            exp_mem[i] = 8'(i) ^ 8'h5A;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_on = 1'b1;
        tick();

        // R1 / R11 reset state
        peek(1'b1, s); check(s == 8'h00, "R1 reset status", s, 8'h00);
        peek(1'b0, d); check(d == 8'h00, "R1 reset data port", d, 8'h00);

        // R2 / R3 flag timing on a control write
        host_sel = 1'b1; host_wdata = 8'h81; host_wr = 1'b1;
        tick(); host_wr = 1'b0;
        peek(1'b1, s); check(s[1] && s[3], "R2 input-full and command flag", s, 8'h0A);
        tick();
        peek(1'b1, s); check(!s[1], "R3 input-full cleared after one edge", s, 8'h08);
        host_write(1'b0, 8'h10);
        peek(1'b1, s); check(!s[3], "R2 data-port flag", s, 8'h00);
        host_write(1'b0, 8'hA7);
        check(mem[8'h10] == 8'hA7, "R6 stored byte", mem[8'h10], 8'hA7);

        // R4 / R5 read back
        ec_rd(8'h10, d); check(d == 8'hA7, "R4 read back written byte", d, 8'hA7);
        peek(1'b1, s); check(!s[0], "R5 output-full cleared by read", s, 8'h00);
        ec_rd(8'h33, d); check(d == (8'h33 ^ 8'h5A), "R4 untouched register", d, 8'h33 ^ 8'h5A);
        ec_wr(8'hFF, 8'h01);
        ec_rd(8'hFF, d); check(d == 8'h01, "R6 top address", d, 8'h01);

        // R7 / R8 burst
        host_write(1'b1, 8'h82);
        peek(1'b1, s); check(s[4] && s[0], "R7 burst flag and reply", s, 8'h11);
        host_read(d); check(d == ACK, "R7 acknowledge byte", d, ACK);
        host_write(1'b1, 8'h82);
        host_write(1'b1, 8'h83);
        peek(1'b1, s); check(!s[4] && s[0], "R8 burst off keeps output-full", s, 8'h09);
        peek(1'b0, d); check(d == ACK, "R8 data port unchanged", d, ACK);
        host_read(d);

        // R9 query
        host_write(1'b1, 8'h84);
        wait_obf("R9 query reply never arrived");
        host_read(d); check(d == QV, "R9 query value", d, QV);

        // R10 abandoned write and unknown opcodes
        host_write(1'b1, 8'h81);
        host_write(1'b0, 8'h20);
        host_write(1'b1, 8'h80);
        host_write(1'b0, 8'h20);
        wait_obf("R10 reply after abandon");
        host_read(d); check(d == (8'h20 ^ 8'h5A), "R10 abandoned write left register", d, 8'h20 ^ 8'h5A);
        host_write(1'b1, 8'h82);
        host_write(1'b1, 8'h81);
        host_write(1'b0, 8'h21);
        host_write(1'b1, 8'h55);
        host_write(1'b0, 8'h99);
        check(mem[8'h21] == (8'h21 ^ 8'h5A), "R10 unknown opcode blocked write", mem[8'h21], 8'h21 ^ 8'h5A);
        peek(1'b1, s); check(s[4] && s[0], "R10 unknown opcode kept burst and reply", s, 8'h11);
        peek(1'b0, d); check(d == ACK, "R10 unknown opcode kept data port", d, ACK);
        host_read(d);
        host_write(1'b0, 8'h44);
        peek(1'b1, s); check(!s[0], "R10 stray data byte ignored", s, 8'h00);
        host_write(1'b1, 8'h83);

        // R5 priority: reply load wins over same-edge read
        host_write(1'b1, 8'h84);
        host_sel = 1'b1; host_wdata = 8'h84; host_wr = 1'b1;
        tick(); host_wr = 1'b0;
        host_sel = 1'b0; host_rd = 1'b1;
        tick(); host_rd = 1'b0;
        peek(1'b1, s); check(s[0], "R5 load beats same-edge read", s, 8'h01);
        host_read(d);

        for (int i = 0; i < 256; i++)
            check(mem[i] == exp_mem[i], "R6 final register space", mem[i], exp_mem[i]);

        tick();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule